// File: doc/BRIEF.md
# NAND Flash Host Register Interface

This block sits on a byte-wide register bus and turns register accesses into raw NAND flash pin activity. A small configuration page holds an enable bit and a 32-bit relocatable base address. While the interface is enabled, a 256-byte operational window at that base address gives software four registers:

- a data port,
- a mode register,
- an interrupt status register,
- an interrupt mask register.

Software issues a flash command or address cycle by setting the latch bits in the mode register and then writing the data port. Plain data transfers go through the data port with both latch bits clear. The mode register also drives chip enable and write protect, and it selects an ECC action. The block itself only signals that action. ECC arithmetic and the flash array live outside it.

Every data-port write pulses a write strobe and raises a maskable interrupt source. Every data-port read pulses a read strobe and returns the byte currently on the flash input bus. Read results come back registered, one cycle after the access.

Top module: `nfi_host_regs`

## Requirements
- R1: After reset every pin output is low except `nf_ce_n`, which is high. `irq` and `rd_valid` are low, the window is disabled, and every register reads 0.
- R2: Config offset 0x04 (page 1, i.e. address 0x104) is the command register. Bit 1 of a write enables the window. The register reads 0x02 when enabled and 0x00 when disabled.
- R3: Config offsets 0x10+k (k = 0..3) write and read byte k (bits 8k+7:8k) of the 32-bit window base, without disturbing the other bytes.
- R4: Address page 0 (bits above 7 all zero) decodes to nothing, and page 1 decodes to the config space. Any other address hits the window only when the interface is enabled and the address with bits 7:0 cleared equals the base. An access that decodes to nothing has no effect and reads 0.
- R5: Window offsets 0..3 are the data port. A write drives the byte onto `nf_io_out` and pulses `nf_we` high for one cycle. A read returns `nf_io_in` as sampled at the access edge and pulses `nf_re` high for one cycle.
- R6: The mode register is at window offset 4 and reads back as written. Its bits drive the pins: bit 0 drives `nf_cle`, bit 1 drives `nf_ale`, bit 4 = 1 drives `nf_ce_n` low, and bit 7 drives `nf_wp`.
- R7: Mode bits 6:5 appear on `ecc_sel`. A mode write with bits 6:5 = 01 (enable) or 11 (reset) gives a one-cycle `ecc_rst` pulse. A write with 00 or 10 (read) gives no pulse.
- R8: Window offset 5 always reads 0x14.
- R9: The interrupt status register is at window offset 6 and the mask register is at offset 7. Both are fully writable and readable, and every data-port write sets status bit 0.
- R10: `irq` is high exactly when mask bit 7 is set and (mask AND status) is nonzero.
- R11: A read returns its byte on `rd_data` with `rd_valid` high in the cycle after the access. Unmapped offsets in either space read 0, and `rd_data` is 0 whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | AW | Byte address |
| acc_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| nf_io_out | output | 8 | Byte driven to the flash bus |
| nf_io_in | input | 8 | Byte from the flash bus |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_ce_n | output | 1 | Chip enable, active low |
| nf_wp | output | 1 | Write protect |
| nf_we | output | 1 | One-cycle write strobe |
| nf_re | output | 1 | One-cycle read strobe |
| ecc_sel | output | 2 | ECC action field of the mode register |
| ecc_rst | output | 1 | One-cycle ECC reset pulse |
| irq | output | 1 | Interrupt request |

## Verification
The following results update at the clock edge that accepts the access and can be observed in the cycle that follows:

- every register update, including the pin levels from the mode register and the status bit set by a data write;
- the strobes and the ECC pulse;
- the read data with its valid flag.

`irq` is a combinational function of the registers, so it also follows one edge after the write that changes them. The bench drives each access at a falling edge and checks the pins at the next falling edge, which lies half a period after the registering edge. A scoreboard monitor compares each read byte against the value queued when the read was issued, whenever `rd_valid` is high at a falling edge. It then checks the strobes and the pulse again one cycle later to confirm that each is a single cycle wide.

// File: rtl/nfi_pkg.sv
package nfi_pkg;
  localparam int BYTE_W   = 8;
  localparam int BASE_W   = 32;
  localparam int BASE_LN  = BASE_W / BYTE_W;

  typedef enum logic [1:0] {RG_NONE, RG_CFG, RG_WIN} region_e;

  // configuration page offsets
  localparam logic [7:0] CF_CMD    = 8'h04;
  localparam logic [7:0] CF_BASE0  = 8'h10;
  localparam int         CF_EN_BIT = 1;

  // window offsets
  localparam logic [7:0] WN_MODE = 8'h04;
  localparam logic [7:0] WN_STAT = 8'h05;
  localparam logic [7:0] WN_ISR  = 8'h06;
  localparam logic [7:0] WN_IMR  = 8'h07;
  localparam logic [7:0] STAT_VAL = 8'h14;

  // mode register bit positions
  localparam int MD_CLE = 0;
  localparam int MD_ALE = 1;
  localparam int MD_CE  = 4;
  localparam int MD_ECC_LO = 5;
  localparam int MD_WP  = 7;
  localparam int IMR_GLOBAL = 7;
endpackage

// File: rtl/nfi_decode.sv
module nfi_decode
  import nfi_pkg::*;
#(
  parameter int AW = 32,
  parameter int CFG_PAGE = 1
) (
  input  logic [AW-1:0]     addr,
  input  logic              win_en,
  input  logic [BASE_W-1:0] base,
  output region_e           region,
  output logic [7:0]        offset
);
  localparam int PW = AW - 8;

  logic [BASE_W-1:0] addr_ext;
  logic [PW-1:0]     page;

  always_comb begin
    addr_ext = BASE_W'(addr);
    addr_ext[7:0] = 8'h00;
    page   = addr[AW-1:8];
    offset = addr[7:0];
    if (page == PW'(0))
      region = RG_NONE;
    else if (page == PW'(CFG_PAGE))
      region = RG_CFG;
    else if (win_en && (addr_ext == base))
      region = RG_WIN;
    else
      region = RG_NONE;
  end
endmodule

// File: rtl/nfi_cfg.sv
module nfi_cfg
  import nfi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        offset,
  input  logic [7:0]        wdata,
  output logic              win_en,
  output logic [BASE_W-1:0] base,
  output logic [7:0]        rd_data
);
  logic en_q, en_d;
  logic [7:0] lane_q [BASE_LN];
  logic [7:0] lane_d [BASE_LN];

  always_comb begin
    en_d = en_q;
    if (wr_en && offset == CF_CMD) en_d = wdata[CF_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  for (genvar k = 0; k < BASE_LN; k++) begin : g_lane
    always_comb begin
      lane_d[k] = lane_q[k];
      if (wr_en && offset == CF_BASE0 + 8'(k)) lane_d[k] = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q[k] <= '0;
      else        lane_q[k] <= lane_d[k];
    end
    assign base[k*BYTE_W +: BYTE_W] = lane_q[k];
  end

  assign win_en = en_q;

  always_comb begin
    rd_data = '0;
    if (offset == CF_CMD) rd_data[CF_EN_BIT] = en_q;
    for (int k = 0; k < BASE_LN; k++)
      if (offset == CF_BASE0 + 8'(k)) rd_data = lane_q[k];
  end
endmodule

// File: rtl/nfi_win.sv
module nfi_win
  import nfi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] offset,
  input  logic [7:0] wdata,
  input  logic [7:0] io_in,
  output logic [7:0] io_out,
  output logic [7:0] mode,
  output logic       we,
  output logic       re,
  output logic       ecc_rst,
  output logic       irq,
  output logic [7:0] rd_data
);
  logic [7:0] mode_q, mode_d, isr_q, isr_d, imr_q, imr_d, io_q, io_d;
  logic we_q, we_d, re_q, re_d, ecc_q, ecc_d;
  logic is_data;

  assign is_data = (offset[7:2] == 6'd0);

  always_comb begin
    mode_d = mode_q;
    isr_d  = isr_q;
    imr_d  = imr_q;
    io_d   = io_q;
    we_d   = 1'b0;
    re_d   = 1'b0;
    ecc_d  = 1'b0;
    if (wr_en) begin
      if (is_data) begin
        io_d     = wdata;
        we_d     = 1'b1;
        isr_d[0] = 1'b1;
      end else begin
        case (offset)
          WN_MODE: begin
            mode_d = wdata;
            ecc_d  = wdata[MD_ECC_LO];  // codes 01 and 11 both reset
          end
          WN_ISR:  isr_d = wdata;
          WN_IMR:  imr_d = wdata;
          default: ;
        endcase
      end
    end
    if (rd_en && is_data) re_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; isr_q <= '0; imr_q <= '0; io_q <= '0;
      we_q <= 1'b0; re_q <= 1'b0; ecc_q <= 1'b0;
    end else begin
      mode_q <= mode_d; isr_q <= isr_d; imr_q <= imr_d; io_q <= io_d;
      we_q <= we_d; re_q <= re_d; ecc_q <= ecc_d;
    end
  end

  assign io_out  = io_q;
  assign mode    = mode_q;
  assign we      = we_q;
  assign re      = re_q;
  assign ecc_rst = ecc_q;
  assign irq     = imr_q[IMR_GLOBAL] & (|(imr_q & isr_q));

  always_comb begin
    rd_data = '0;
    if (is_data) rd_data = io_in;
    else begin
      case (offset)
        WN_MODE: rd_data = mode_q;
        WN_STAT: rd_data = STAT_VAL;
        WN_ISR:  rd_data = isr_q;
        WN_IMR:  rd_data = imr_q;
        default: rd_data = '0;
      endcase
    end
  end

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> imr_q[IMR_GLOBAL]);
  // R5
  we_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> $past(wr_en && is_data));
  // R7
  ecc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ecc_rst |-> $past(wr_en && offset == WN_MODE));
  // R9
  isr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && is_data) |=> isr_q[0]);
endmodule

// File: rtl/nfi_host_regs.sv
module nfi_host_regs
  import nfi_pkg::*;
#(
  parameter int AW = 32,
  parameter int CFG_PAGE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [7:0]    acc_wdata,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic [7:0]    nf_io_out,
  input  logic [7:0]    nf_io_in,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic          nf_ce_n,
  output logic          nf_wp,
  output logic          nf_we,
  output logic          nf_re,
  output logic [1:0]    ecc_sel,
  output logic          ecc_rst,
  output logic          irq
);
  region_e           region;
  logic [7:0]        offset, cfg_rd, win_rd, mode;
  logic              win_en;
  logic [BASE_W-1:0] base;
  logic              cfg_wr, win_wr, win_rdreq, any_rd;
  logic [7:0]        rdat_d, rdat_q;
  logic              rval_q;

  nfi_decode #(.AW(AW), .CFG_PAGE(CFG_PAGE)) u_dec (
    .addr(acc_addr), .win_en(win_en), .base(base),
    .region(region), .offset(offset));

  assign cfg_wr    = acc_valid &  acc_write & (region == RG_CFG);
  assign win_wr    = acc_valid &  acc_write & (region == RG_WIN);
  assign win_rdreq = acc_valid & ~acc_write & (region == RG_WIN);
  assign any_rd    = acc_valid & ~acc_write;

  nfi_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .offset(offset),
    .wdata(acc_wdata), .win_en(win_en), .base(base), .rd_data(cfg_rd));

  nfi_win u_win (
    .clk(clk), .rst_n(rst_n), .wr_en(win_wr), .rd_en(win_rdreq),
    .offset(offset), .wdata(acc_wdata), .io_in(nf_io_in),
    .io_out(nf_io_out), .mode(mode), .we(nf_we), .re(nf_re),
    .ecc_rst(ecc_rst), .irq(irq), .rd_data(win_rd));

  always_comb begin
    rdat_d = '0;
    if (any_rd) begin
      case (region)
        RG_CFG:  rdat_d = cfg_rd;
        RG_WIN:  rdat_d = win_rd;
        default: rdat_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdat_q <= '0;
      rval_q <= 1'b0;
    end else begin
      rdat_q <= rdat_d;
      rval_q <= any_rd;
    end
  end

  assign rd_valid = rval_q;
  assign rd_data  = rdat_q;
  assign nf_cle   = mode[MD_CLE];
  assign nf_ale   = mode[MD_ALE];
  assign nf_ce_n  = ~mode[MD_CE];
  assign nf_wp    = mode[MD_WP];
  assign ecc_sel  = mode[MD_ECC_LO+1:MD_ECC_LO];

  // R8
  status_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_rdreq && offset == WN_STAT) |=> (rd_valid && rd_data == STAT_VAL));
  // R11
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> rd_data == 8'h00);
  // R11
  rvalid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_rd |=> rd_valid);
  // R4
  window_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !win_en && acc_addr[AW-1:8] != (AW-8)'(CFG_PAGE))
      |=> $stable(nf_io_out) && !nf_we);
endmodule

// File: tb/nfi_host_regs_tb_top.sv
`timescale 1ns/100ps
module nfi_host_regs_tb_top;
  localparam int AW = 32;
  localparam logic [31:0] BASE = 32'h0012_3400;
  localparam logic [31:0] CFG  = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0, nf_io_in = '0;
  logic rd_valid, nf_cle, nf_ale, nf_ce_n, nf_wp, nf_we, nf_re, ecc_rst, irq;
  logic [7:0] rd_data, nf_io_out;
  logic [1:0] ecc_sel;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  nfi_host_regs #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .nf_io_out(nf_io_out), .nf_io_in(nf_io_in),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_ce_n(nf_ce_n), .nf_wp(nf_wp),
    .nf_we(nf_we), .nf_re(nf_re), .ecc_sel(ecc_sel), .ecc_rst(ecc_rst),
    .irq(irq));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one access; returns at the falling edge after the registering edge
  task automatic acc(bit wr, logic [31:0] a, logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wr(logic [31:0] a, logic [7:0] d);
    acc(1'b1, a, d);
  endtask

  task automatic rd(logic [31:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    acc(1'b0, a, 8'h00);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R11 unexpected rd_valid", 1, 0);
      else chk(tag_q.pop_front(), {24'h0, rd_data}, {24'h0, exp_q.pop_front()});
    end else if (rst_n && !done) begin
      if (rd_data !== 8'h00) chk("R11 idle rd_data", {24'h0, rd_data}, 0);
    end
  end

  task automatic finish_run();
    done = 1;
    if (exp_q.size() != 0) chk("R11 missing reads", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    chk("watchdog", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", nf_ce_n, 1);
    chk("R1 pins", {nf_cle, nf_ale, nf_wp, nf_we, nf_re, ecc_rst, irq, rd_valid}, 0);
    chk("R1 io_out", nf_io_out, 0);
    rd(CFG + 32'h04, 8'h00, "R1 R2 cmd after reset");
    rd(BASE + 32'h05, 8'h00, "R4 window disabled read");

    // R3 base lanes
    wr(CFG + 32'h11, 8'h34);
    wr(CFG + 32'h12, 8'h12);
    wr(CFG + 32'h10, 8'h00);
    rd(CFG + 32'h11, 8'h34, "R3 lane1");
    rd(CFG + 32'h12, 8'h12, "R3 lane2");
    rd(CFG + 32'h13, 8'h00, "R3 lane3");

    // R4 before enable: no effect
    wr(BASE, 8'h5A);
    chk("R4 no strobe when disabled", nf_we, 0);
    chk("R4 io_out untouched", nf_io_out, 0);

    // R2 enable (other bits set too)
    wr(CFG + 32'h04, 8'hFF);
    rd(CFG + 32'h04, 8'h02, "R2 enabled readback");

    // R6 mode pins
    wr(BASE + 32'h04, 8'h91);
    chk("R6 cle", nf_cle, 1); chk("R6 ale", nf_ale, 0);
    chk("R6 ce_n", nf_ce_n, 0); chk("R6 wp", nf_wp, 1);
    chk("R7 no ecc pulse for 00", ecc_rst, 0);
    rd(BASE + 32'h04, 8'h91, "R6 mode readback");
    wr(BASE + 32'h04, 8'h02);
    chk("R6 ale only", {nf_cle, nf_ale, nf_ce_n, nf_wp}, 4'b0110);

    // R5 data write at offset 2
    wr(BASE + 32'h02, 8'hA5);
    chk("R5 we pulse", nf_we, 1);
    chk("R5 io_out", nf_io_out, 8'hA5);
    @(negedge clk);
    chk("R5 we one cycle", nf_we, 0);

    // R9 / R10
    rd(BASE + 32'h06, 8'h01, "R9 isr bit0 after data write");
    chk("R10 irq masked", irq, 0);
    wr(BASE + 32'h07, 8'h01);
    chk("R10 no global enable", irq, 0);
    wr(BASE + 32'h07, 8'h81);
    chk("R10 irq asserted", irq, 1);
    wr(BASE + 32'h06, 8'h00);
    chk("R10 irq cleared by isr write", irq, 0);
    wr(BASE + 32'h07, 8'h80);
    wr(BASE + 32'h00, 8'h11);
    chk("R10 bit0 not in mask", irq, 0);
    wr(BASE + 32'h06, 8'hC3);
    chk("R10 bit7 overlap", irq, 1);
    rd(BASE + 32'h06, 8'hC3, "R9 isr readback");
    rd(BASE + 32'h07, 8'h80, "R9 imr readback");

    // R8 status
    rd(BASE + 32'h05, 8'h14, "R8 status");

    // R5 read path
    nf_io_in = 8'h3C;
    rd(BASE + 32'h03, 8'h3C, "R5 data read");
    chk("R5 re pulse", nf_re, 1);
    @(negedge clk);
    chk("R5 re one cycle", nf_re, 0);

    // R7 ECC actions
    wr(BASE + 32'h04, 8'h20);
    chk("R7 pulse for 01", ecc_rst, 1); chk("R7 sel 01", ecc_sel, 2'b01);
    @(negedge clk);
    chk("R7 pulse one cycle", ecc_rst, 0);
    wr(BASE + 32'h04, 8'h40);
    chk("R7 no pulse for 10", ecc_rst, 0); chk("R7 sel 10", ecc_sel, 2'b10);
    wr(BASE + 32'h04, 8'h60);
    chk("R7 pulse for 11", ecc_rst, 1);

    // R11 unmapped offsets
    rd(BASE + 32'h08, 8'h00, "R11 window unmapped");
    rd(CFG + 32'h05, 8'h00, "R11 config unmapped");

    // R4 mismatched page, page 0
    wr(BASE + 32'h100, 8'hEE);
    chk("R4 other page no strobe", nf_we, 0);
    chk("R4 other page io_out", nf_io_out, 8'h11);
    rd(32'h0000_0004, 8'h00, "R4 page0 read");

    // R4 disable again
    wr(BASE + 32'h04, 8'h91);
    wr(CFG + 32'h04, 8'h00);
    wr(BASE + 32'h01, 8'h77);
    chk("R4 disabled no strobe", nf_we, 0);
    chk("R4 disabled io_out", nf_io_out, 8'h11);
    rd(BASE + 32'h04, 8'h00, "R4 disabled read");
    chk("R4 mode pins kept", {nf_cle, nf_ce_n, nf_wp}, 3'b101);
    rd(CFG + 32'h04, 8'h00, "R2 disabled readback");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule